// File: doc/BRIEF.md
# CAN bit timing generator

This block turns a peripheral clock into nominal CAN bit timing. A 16-bit configuration word sets four values. A prescaler divides the clock into time quanta. Two segment lengths place the sample point inside a bit. A jump width bounds how far the timing may move when it follows the bus. Each field takes effect as its stored value plus one. Software can change the word only while two controller mode flags are both high. The reset value gives a 2-clock quantum and an 8-quantum bit.

The block counts quanta through a one-quantum sync segment, then the segment before the sample point, then the segment after it. It raises a one-clock strobe at the sample point and another at the end of the bit, and it holds the level of the receive line taken at the last sample point. The receive line passes through two registers. A falling (recessive-to-dominant) transition seen there either restarts the bit, when hard synchronisation is requested, or shifts the sample point by at most the jump width. The shift happens at most once per bit.

Top module: `can_bit_timer`

## Requirements
- R1: After reset the configuration reads 0x2301. A write stores bits 14:0, and bit 15 always reads 0 whatever was written.
- R2: A write changes the configuration only when `ccEnable` and `initMode` are both 1. In every other case the stored word is unchanged.
- R3: Field positions: bits 5:0 are the prescaler P, bits 7:6 the jump width J, bits 11:8 the pre-sample segment A and bits 14:12 the post-sample segment B. One quantum lasts P+1 clocks.
- R4: With no receive edges, one bitPulse follows another every (P+1)·(1+(A+1)+(B+1)) clocks.
- R5: A stored A of 0 behaves as A = 1, so the pre-sample segment lasts at least 2 quanta.
- R6: samplePulse is high for one clock, in the last clock of the pre-sample segment. bitPulse is high for one clock, in the last clock of the post-sample segment. bitPulse comes (P+1)·(B+1) clocks after samplePulse, and the two are never high together.
- R7: bitValue resets to 1. At each samplePulse it takes the receive level registered two clocks earlier.
- R8: A falling transition of rxIn while hardSyncReq is 1 restarts the bit with no length limit. The sync quantum starts two clock edges after rxIn falls.
- R9: A falling edge in the pre-sample segment lengthens that segment by the number of quanta elapsed in it, counting the current one, but by no more than J+1 quanta.
- R10: A falling edge in the post-sample segment shortens that segment by min(J+1, remaining quanta − 1). At the earliest, the bit then ends with the current quantum.
- R11: Only one resynchronisation applies per bit. Further edges in the same bit are ignored, and the limit clears at the bit boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 16 | Configuration write data |
| ccEnable | input | 1 | Configuration-change-enable mode flag |
| initMode | input | 1 | Initialisation mode flag |
| cfgRdData | output | 16 | Stored configuration, bit 15 reads 0 |
| rxIn | input | 1 | Receive line, 1 recessive and 0 dominant |
| hardSyncReq | input | 1 | Bus idle: next falling edge hard-synchronises |
| samplePulse | output | 1 | One-clock strobe at the sample point |
| bitPulse | output | 1 | One-clock strobe at the bit end |
| bitValue | output | 1 | Receive level taken at the last sample point |

## Verification
Two events can fall in the same cycle. One is a resynchronisation edge. The other is the end of the segment that the edge adjusts. When an edge lands late in the post-sample segment, the shortening and the bit-end decision are made in the same clock. The bench provokes this by lowering rxIn so that the edge reaches the second of four post-sample quanta. It then checks that bitPulse arrives two quanta early and that the following sample point is counted from that new boundary. A second run drops, raises and drops rxIn again within one pre-sample segment, and the measured sample point shows that only the first edge moved it.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  localparam int BRP_W = 6;
  localparam int TS1_W = 4;
  localparam int TS2_W = 3;
  localparam int SJW_W = 2;
  localparam int CFG_W = 16;
  localparam int Q_W   = TS1_W + 2;

  typedef enum logic [1:0] {SEG_SYNC, SEG_PRE, SEG_POST} seg_e;

  typedef struct packed {
    logic [TS2_W-1:0] tseg2;
    logic [TS1_W-1:0] tseg1;
    logic [SJW_W-1:0] sjw;
    logic [BRP_W-1:0] brp;
  } timing_t;

  typedef struct packed {
    logic sampleStb;
    logic bitStb;
    logic restart;
  } strobe_t;
endpackage

// File: rtl/can_bt_dp.sv
module can_bt_dp
  import can_bt_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_CFG = 16'h2301
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             ccEnable,
  input  logic             initMode,
  input  logic             rxIn,
  input  strobe_t          stb,
  output timing_t          cfg,
  output logic [CFG_W-1:0] cfgRdData,
  output logic             tqTick,
  output logic             fallEdge,
  output logic             bitValue
);
  localparam logic [CFG_W-1:0] RESV_MASK = {1'b0, {(CFG_W-1){1'b1}}};

  logic [CFG_W-1:0] cfgReg;
  logic [BRP_W-1:0] preCnt;
  logic             rxD1, rxD2;
  logic             wrOk;

  assign wrOk      = cfgWrEn & ccEnable & initMode;
  assign cfg       = timing_t'(cfgReg[CFG_W-2:0]);
  assign cfgRdData = cfgReg;
  assign tqTick    = (preCnt >= cfg.brp);
  assign fallEdge  = rxD2 & ~rxD1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= RESET_CFG & RESV_MASK;
    end else if (wrOk) begin
      cfgReg <= cfgWrData & RESV_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (stb.restart || tqTick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxD1     <= 1'b1;
      rxD2     <= 1'b1;
      bitValue <= 1'b1;
    end else begin
      rxD1 <= rxIn;
      rxD2 <= rxD1;
      if (stb.sampleStb) bitValue <= rxD1;
    end
  end

  // R2
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgWrEn && ccEnable && initMode) |=> $stable(cfgRdData));

  // R1
  wr_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && ccEnable && initMode) |=> cfgRdData == {1'b0, $past(cfgWrData[CFG_W-2:0])});

  // R7
  bit_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.sampleStb |=> bitValue == $past(rxIn, 2));
endmodule

// File: rtl/can_bt_ctrl.sv
module can_bt_ctrl
  import can_bt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [TS1_W-1:0] tseg1,
  input  logic [TS2_W-1:0] tseg2,
  input  logic [SJW_W-1:0] sjw,
  input  logic             tqTick,
  input  logic             fallEdge,
  input  logic             hardSyncReq,
  output strobe_t          stb
);
  seg_e           seg;
  logic [Q_W-1:0] qCnt, adj, newAdj, adjEff, rem;
  logic [Q_W-1:0] seg1Len, seg2Len, sjwLen;
  logic           synced, hardNow, resyncNow, seg1End, seg2End;

  assign seg1Len = Q_W'((tseg1 == '0) ? TS1_W'(1) : tseg1) + 1'b1;
  assign seg2Len = Q_W'(tseg2) + 1'b1;
  assign sjwLen  = Q_W'(sjw) + 1'b1;

  assign hardNow   = fallEdge & hardSyncReq;
  assign resyncNow = fallEdge & ~hardSyncReq & ~synced & (seg != SEG_SYNC);

  always_comb begin
    rem    = seg2Len - qCnt;
    newAdj = '0;
    if (seg == SEG_PRE) begin
      newAdj = ((qCnt + 1'b1) < sjwLen) ? qCnt + 1'b1 : sjwLen;
    end else if (seg == SEG_POST) begin
      newAdj = ((rem - 1'b1) < sjwLen) ? rem - 1'b1 : sjwLen;
    end
    adjEff = resyncNow ? newAdj : adj;
  end

  assign seg1End = tqTick && (seg == SEG_PRE)  && (qCnt >= seg1Len - 1'b1 + adjEff);
  assign seg2End = tqTick && (seg == SEG_POST) && ((qCnt + adjEff) >= seg2Len - 1'b1);

  assign stb.sampleStb = seg1End & ~hardNow;
  assign stb.bitStb    = seg2End & ~hardNow;
  assign stb.restart   = hardNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seg    <= SEG_SYNC;
      qCnt   <= '0;
      adj    <= '0;
      synced <= 1'b0;
    end else if (hardNow) begin
      seg    <= SEG_SYNC;
      qCnt   <= '0;
      adj    <= '0;
      synced <= 1'b1;
    end else begin
      if (resyncNow) begin
        adj    <= newAdj;
        synced <= 1'b1;
      end
      if (tqTick) begin
        case (seg)
          SEG_SYNC: begin
            seg  <= SEG_PRE;
            qCnt <= '0;
          end
          SEG_PRE: begin
            if (seg1End) begin
              seg  <= SEG_POST;
              qCnt <= '0;
              adj  <= '0;
            end else begin
              qCnt <= qCnt + 1'b1;
            end
          end
          default: begin
            if (seg2End) begin
              seg    <= SEG_SYNC;
              qCnt   <= '0;
              adj    <= '0;
              synced <= 1'b0;
            end else begin
              qCnt <= qCnt + 1'b1;
            end
          end
        endcase
      end
    end
  end

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.sampleStb && stb.bitStb));

  // R6
  sample_to_post_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.sampleStb |=> seg == SEG_POST);

  // R8
  hard_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    hardNow |=> (seg == SEG_SYNC) && (qCnt == '0));

  // R9
  jump_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    resyncNow |=> adj <= $past(sjwLen));

  // R11
  one_resync_chk: assert property (@(posedge clk) disable iff (!rstN)
    (synced && !stb.bitStb) |=> synced);
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
#(
  parameter logic [15:0] RESET_CFG = 16'h2301
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [15:0] cfgWrData,
  input  logic        ccEnable,
  input  logic        initMode,
  output logic [15:0] cfgRdData,
  input  logic        rxIn,
  input  logic        hardSyncReq,
  output logic        samplePulse,
  output logic        bitPulse,
  output logic        bitValue
);
  timing_t cfg;
  strobe_t stb;
  logic    tqTick, fallEdge;

  can_bt_dp #(.RESET_CFG(RESET_CFG)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .ccEnable(ccEnable), .initMode(initMode), .rxIn(rxIn), .stb(stb),
    .cfg(cfg), .cfgRdData(cfgRdData), .tqTick(tqTick), .fallEdge(fallEdge),
    .bitValue(bitValue)
  );

  can_bt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tseg1(cfg.tseg1), .tseg2(cfg.tseg2), .sjw(cfg.sjw),
    .tqTick(tqTick), .fallEdge(fallEdge), .hardSyncReq(hardSyncReq), .stb(stb)
  );

  assign samplePulse = stb.sampleStb;
  assign bitPulse    = stb.bitStb;
endmodule

// File: tb/can_bit_timer_bench.sv
`timescale 1ns/1ps
module can_bit_timer_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN, cfgWrEn, ccEnable, initMode, rxIn, hardSyncReq;
  logic [15:0] cfgWrData, cfgRdData;
  logic        samplePulse, bitPulse, bitValue;
  int checks = 0;
  int errors = 0;

  can_bit_timer u_can_bit_timer (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .ccEnable(ccEnable), .initMode(initMode), .cfgRdData(cfgRdData),
    .rxIn(rxIn), .hardSyncReq(hardSyncReq), .samplePulse(samplePulse),
    .bitPulse(bitPulse), .bitValue(bitValue)
  );

  // config word, bit period in clocks, sample-to-bit gap in clocks, read-back
  localparam int NV = 6;
  localparam logic [15:0] V_CFG  [NV] = '{16'h2301, 16'h0000, 16'h7F00, 16'h1402, 16'h23C0, 16'hA301};
  localparam int          V_PER  [NV] = '{16, 4, 25, 24, 8, 16};  // row 2: R5 clamp of A=0
  localparam int          V_GAP  [NV] = '{6, 1, 8, 6, 3, 6};
  localparam logic [15:0] V_READ [NV] = '{16'h2301, 16'h0000, 16'h7F00, 16'h1402, 16'h23C0, 16'h2301};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [15:0] d, input logic cce, input logic ini);
    @(negedge clk);
    cfgWrData = d; ccEnable = cce; initMode = ini; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0; ccEnable = 1'b0; initMode = 1'b0;
  endtask

  task automatic waitBit();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!bitPulse && n < 5000);
  endtask

  task automatic measure(output int per, output int gap);
    int s = -1;
    int b = -1;
    waitBit();
    for (int i = 1; i <= 3000 && b < 0; i++) begin
      @(negedge clk);
      if (samplePulse && s < 0) s = i;
      if (bitPulse) b = i;
    end
    per = b;
    gap = b - s;
  endtask

  task automatic resyncRun(input logic [15:0] c, input int fallAt, input int riseAt,
                           input int fall2At, output int s1, output int b1, output int s2);
    s1 = -1; b1 = -1; s2 = -1;
    writeCfg(c, 1'b1, 1'b1);
    rxIn = 1'b1;
    waitBit();
    waitBit();
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (samplePulse && s1 < 0) s1 = i;
      else if (samplePulse && b1 >= 0 && s2 < 0) s2 = i;
      if (bitPulse && b1 < 0) b1 = i;
      if (i == fallAt || i == fall2At) rxIn = 1'b0;
      if (i == riseAt) rxIn = 1'b1;
    end
    rxIn = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int per, gap, s1, b1, s2, sh, bh;
    rstN = 1'b0; cfgWrEn = 1'b0; cfgWrData = '0; ccEnable = 1'b0;
    initMode = 1'b0; rxIn = 1'b1; hardSyncReq = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(cfgRdData == 16'h2301, "R1 reset cfg", cfgRdData, 16'h2301);
    check(bitValue == 1'b1, "R7 reset bitValue", bitValue, 1);
    check(!samplePulse && !bitPulse, "R6 reset strobes", {samplePulse, bitPulse}, 0);

    writeCfg(16'h1111, 1'b1, 1'b0);
    check(cfgRdData == 16'h2301, "R2 lock init=0", cfgRdData, 16'h2301);
    writeCfg(16'h1111, 1'b0, 1'b1);
    check(cfgRdData == 16'h2301, "R2 lock cce=0", cfgRdData, 16'h2301);

    for (int v = 0; v < NV; v++) begin
      writeCfg(V_CFG[v], 1'b1, 1'b1);
      check(cfgRdData == V_READ[v], "R1 readback", cfgRdData, V_READ[v]);
      waitBit();
      measure(per, gap);
      check(per == V_PER[v], "R3 R4 bit period", per, V_PER[v]);
      check(gap == V_GAP[v], "R6 sample-to-bit gap", gap, V_GAP[v]);
    end

    writeCfg(16'h2301, 1'b1, 1'b1);
    rxIn = 1'b0;
    waitBit(); waitBit();
    check(bitValue == 1'b0, "R7 dominant sampled", bitValue, 0);
    rxIn = 1'b1;
    waitBit(); waitBit();
    check(bitValue == 1'b1, "R7 recessive sampled", bitValue, 1);

    writeCfg(16'h2300, 1'b1, 1'b1);
    waitBit(); waitBit();
    @(negedge clk);
    hardSyncReq = 1'b1; rxIn = 1'b0;
    sh = -1; bh = -1;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (i >= 2 && samplePulse && sh < 0) sh = i;
      if (i >= 2 && bitPulse && bh < 0) bh = i;
    end
    check(sh == 6, "R8 sample after hard sync", sh, 6);
    check(bh == 9, "R8 bit end after hard sync", bh, 9);
    hardSyncReq = 1'b0; rxIn = 1'b1;

    resyncRun(16'h37C0, 2, 4, 5, s1, b1, s2);
    check(s1 == 11, "R11 second edge ignored", s1, 11);
    check(b1 == 15, "R9 lengthened bit end", b1, 15);

    resyncRun(16'h3700, 4, -1, -1, s1, b1, s2);
    check(s1 == 10, "R9 jump width clip", s1, 10);
    check(b1 == 14, "R9 clipped bit end", b1, 14);

    resyncRun(16'h37C0, 10, -1, -1, s1, b1, s2);
    check(s1 == 9, "R10 nominal sample", s1, 9);
    check(b1 == 11, "R10 shortened bit end", b1, 11);
    check(s2 == 20, "R10 next sample from new edge", s2, 20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule